// File: doc/BRIEF.md
# Indirect I/O Window Controller

This block gives a host on a primary bus a narrow window into the I/O space of a secondary bus. The host loads a target I/O address into a window address register. It then touches a window data register with an I/O-type access. That touch starts one transaction on the secondary master port, using the stored address, the host's own byte enables and the host's direction.

The transfer is delayed. The host is answered with retry until the secondary side has finished. When the host repeats the same access after that, it receives a normal completion, which carries the captured read data for a read.

A semaphore bit arbitrates between hosts but does not enforce anything. Reading the semaphore from the primary side hands back its old value and leaves it set. Delivering a completion clears it. A read-only shadow of the semaphore sits in the control register so that software can inspect it without claiming it.

The sequencing lives in a three-state machine:
- **ST_IDLE**: nothing is outstanding. A qualified data access takes the transition LAUNCH to ST_ISSUE.
- **ST_ISSUE**: the secondary request is held. Seeing `s_done` takes the transition FINISH to ST_READY.
- **ST_READY**: the result is held for the repeat. A matching repeat takes the transition DELIVER back to ST_IDLE. A non-matching access stays in ST_READY and is retried.

Top module: `iow_ctrl`

## Requirements
- R1: Every cycle with `p_req` high is answered by `p_rsp_vld` high exactly one cycle later. A cycle without `p_req` produces no response in the next cycle.
- R2: Register select codes on `p_sel` are as follows:
  - 0 is the window address, read/write over the full width.
  - 1 is the window data register.
  - 2 is control: bit 0 is the enable (read/write), bit 8 is the read-only semaphore shadow, and other bits read 0.
  - 3 is the semaphore: bit 0 holds it, other bits read 0, and writes are ignored.
  - Writes to registers 0 and 2 are whole-word, and `p_be` does not mask them.
- R3: A data-register access is a reserved access when it is memory-type (`p_io`=0) or arrives from the secondary side (`p_from_sec`=1). A reserved access launches nothing, is not retried, reads 0, and has its write data ignored.
- R4: While the control enable bit is 0, every data-register access is a reserved access, as in R3.
- R5: A launched secondary request carries the following, and holds all of them stable with `s_req` high until `s_done`:
  - the window address exactly as stored, including bits [1:0] even when they disagree with the byte enables;
  - the initiator's `p_be` and direction;
  - for a write, the initiator's write data.
- R6: Every qualified data access is answered with retry until the secondary transaction has completed. This includes the launching access and any repeat made while the request is outstanding. After completion, an access whose direction or byte enables differ from the latched ones is also retried.
- R7: After completion, a repeat with matching direction and byte enables gets a non-retry response. A read returns the captured `s_rdata` and a write returns 0. The block is then free to launch again.
- R8: A primary-side read of the semaphore returns its previous value and leaves it set to 1. A secondary-side read returns the value without changing it.
- R9: The semaphore clears to 0 in the same cycle that the completion of R7 is delivered.
- R10: Reading the control register never changes the semaphore.
- R11: The semaphore enforces nothing. Address and control writes take effect whatever its value.
- R12: After reset the following all read 0: the semaphore, the enable, the window address and the window data. No transaction is outstanding, and `s_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| p_req | input | 1 | Register access strobe, one cycle per access |
| p_from_sec | input | 1 | Access originates on the secondary side |
| p_io | input | 1 | Access is I/O-type (0 = memory-type) |
| p_wr | input | 1 | 1 = write, 0 = read |
| p_sel | input | 2 | Register select |
| p_be | input | DW/8 | Initiator byte enables |
| p_wdata | input | DW | Write data |
| p_rsp_vld | output | 1 | Response valid, one cycle after `p_req` |
| p_rsp_retry | output | 1 | Response is a retry |
| p_rsp_rdata | output | DW | Read data of the response |
| s_req | output | 1 | Secondary I/O request, held until `s_done` |
| s_wr | output | 1 | Secondary request direction |
| s_addr | output | AW | Secondary I/O address |
| s_be | output | DW/8 | Secondary byte enables |
| s_wdata | output | DW | Secondary write data |
| s_done | input | 1 | Secondary transaction finished |
| s_rdata | input | DW | Secondary read data, valid with `s_done` |

## Verification
A state machine stuck in ST_ISSUE or ST_READY shows at the ports within one cycle of the next data access. That access either keeps getting retried or is completed too early. A lost launch shows as `s_req` staying low one cycle after the launching access. A semaphore that sets or clears on the wrong event is visible on the very next read of the control shadow. Latching errors appear on `s_addr`, `s_be` and `s_wdata` in the first cycle of the request, or as the wrong data in the completing read response.

// File: rtl/iow_pkg.sv
package iow_pkg;

    localparam int SELW = 2;

    localparam logic [SELW-1:0] SEL_ADDR = 2'd0;
    localparam logic [SELW-1:0] SEL_DATA = 2'd1;
    localparam logic [SELW-1:0] SEL_CTRL = 2'd2;
    localparam logic [SELW-1:0] SEL_OWN  = 2'd3;

    localparam int CTRL_EN_BIT  = 0;
    localparam int CTRL_OWN_BIT = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_READY = 2'd2
    } xact_state_e;

endpackage

// File: rtl/iow_cfg.sv
module iow_cfg #(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    p_req,
    input  logic                    p_from_sec,
    input  logic                    p_wr,
    input  logic [iow_pkg::SELW-1:0] p_sel,
    input  logic [DW-1:0]           p_wdata,
    input  logic                    cpl,
    output logic [AW-1:0]           addr_q,
    output logic                    en_q,
    output logic                    own_q
);
    import iow_pkg::*;

    logic addr_we, ctrl_we, own_claim;

    always_comb begin
        addr_we   = p_req && p_wr && (p_sel == SEL_ADDR);
        ctrl_we   = p_req && p_wr && (p_sel == SEL_CTRL);
        own_claim = p_req && !p_wr && !p_from_sec && (p_sel == SEL_OWN);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            en_q   <= 1'b0;
            own_q  <= 1'b0;
        end else begin
            if (addr_we) addr_q <= p_wdata[AW-1:0];
            if (ctrl_we) en_q   <= p_wdata[CTRL_EN_BIT];
            if (cpl)            own_q <= 1'b0;
            else if (own_claim) own_q <= 1'b1;
        end
    end

endmodule

// File: rtl/iow_xact.sv
module iow_xact #(
    parameter int AW = 32,
    parameter int DW = 32,
    localparam int BEW = DW / 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           acc_vld,
    input  logic           acc_wr,
    input  logic [BEW-1:0] acc_be,
    input  logic [DW-1:0]  acc_wdata,
    input  logic [AW-1:0]  win_addr,
    output logic           acc_retry,
    output logic           acc_cpl,
    output logic [DW-1:0]  data_q,
    output logic           s_req,
    output logic           s_wr,
    output logic [AW-1:0]  s_addr,
    output logic [BEW-1:0] s_be,
    output logic [DW-1:0]  s_wdata,
    input  logic           s_done,
    input  logic [DW-1:0]  s_rdata
);
    import iow_pkg::*;

    xact_state_e state_q, state_d;
    logic        wr_q;
    logic [BEW-1:0] be_q;
    logic [AW-1:0]  addr_lq;
    logic        match;

    // state register and datapath latches
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            wr_q    <= 1'b0;
            be_q    <= '0;
            addr_lq <= '0;
            data_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && acc_vld) begin
                wr_q    <= acc_wr;
                be_q    <= acc_be;
                addr_lq <= win_addr;
                if (acc_wr) data_q <= acc_wdata;
            end
            if (state_q == ST_ISSUE && s_done && !wr_q) data_q <= s_rdata;
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        acc_retry = 1'b0;
        acc_cpl   = 1'b0;
        match     = acc_vld && (acc_wr == wr_q) && (acc_be == be_q);
        unique case (state_q)
            ST_IDLE: begin
                if (acc_vld) begin
                    acc_retry = 1'b1;
                    state_d   = ST_ISSUE;      // LAUNCH
                end
            end
            ST_ISSUE: begin
                acc_retry = acc_vld;
                if (s_done) state_d = ST_READY; // FINISH
            end
            ST_READY: begin
                if (match) begin
                    acc_cpl = 1'b1;
                    state_d = ST_IDLE;          // DELIVER
                end else begin
                    acc_retry = acc_vld;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        s_req   = (state_q == ST_ISSUE);
        s_wr    = wr_q;
        s_addr  = addr_lq;
        s_be    = be_q;
        s_wdata = data_q;
    end

endmodule

// File: rtl/iow_ctrl.sv
module iow_ctrl #(
    parameter int AW = 32,
    parameter int DW = 32,
    localparam int BEW = DW / 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     p_req,
    input  logic                     p_from_sec,
    input  logic                     p_io,
    input  logic                     p_wr,
    input  logic [iow_pkg::SELW-1:0] p_sel,
    input  logic [BEW-1:0]           p_be,
    input  logic [DW-1:0]            p_wdata,
    output logic                     p_rsp_vld,
    output logic                     p_rsp_retry,
    output logic [DW-1:0]            p_rsp_rdata,
    output logic                     s_req,
    output logic                     s_wr,
    output logic [AW-1:0]            s_addr,
    output logic [BEW-1:0]           s_be,
    output logic [DW-1:0]            s_wdata,
    input  logic                     s_done,
    input  logic [DW-1:0]            s_rdata
);
    import iow_pkg::*;

    logic [AW-1:0] addr_q;
    logic          en_q, own_q;
    logic          data_ok, acc_retry, acc_cpl;
    logic [DW-1:0] data_q;
    logic [DW-1:0] rdata_d;

    assign data_ok = p_req && (p_sel == SEL_DATA) && p_io && !p_from_sec && en_q;

    iow_cfg #(.AW(AW), .DW(DW)) cfg_i (
        .clk(clk), .rst_n(rst_n), .p_req(p_req), .p_from_sec(p_from_sec),
        .p_wr(p_wr), .p_sel(p_sel), .p_wdata(p_wdata), .cpl(acc_cpl),
        .addr_q(addr_q), .en_q(en_q), .own_q(own_q)
    );

    iow_xact #(.AW(AW), .DW(DW)) xact_i (
        .clk(clk), .rst_n(rst_n), .acc_vld(data_ok), .acc_wr(p_wr),
        .acc_be(p_be), .acc_wdata(p_wdata), .win_addr(addr_q),
        .acc_retry(acc_retry), .acc_cpl(acc_cpl), .data_q(data_q),
        .s_req(s_req), .s_wr(s_wr), .s_addr(s_addr), .s_be(s_be),
        .s_wdata(s_wdata), .s_done(s_done), .s_rdata(s_rdata)
    );

    always_comb begin
        rdata_d = '0;
        if (!p_wr) begin
            unique case (p_sel)
                SEL_ADDR: rdata_d[AW-1:0] = addr_q;
                SEL_DATA: if (acc_cpl) rdata_d = data_q;
                SEL_CTRL: begin
                    rdata_d[CTRL_EN_BIT]  = en_q;
                    rdata_d[CTRL_OWN_BIT] = own_q;
                end
                SEL_OWN:  rdata_d[0] = own_q;
                default:  rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_rsp_vld   <= 1'b0;
            p_rsp_retry <= 1'b0;
            p_rsp_rdata <= '0;
        end else begin
            p_rsp_vld   <= p_req;
            p_rsp_retry <= p_req && acc_retry;
            p_rsp_rdata <= p_req ? rdata_d : '0;
        end
    end

endmodule

// File: rtl/iow_ctrl_chk.sv
module iow_ctrl_chk #(
    parameter int AW = 32,
    parameter int DW = 32,
    localparam int BEW = DW / 8
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     p_req,
    input logic                     p_from_sec,
    input logic                     p_io,
    input logic                     p_wr,
    input logic [iow_pkg::SELW-1:0] p_sel,
    input logic                     p_rsp_vld,
    input logic                     p_rsp_retry,
    input logic [DW-1:0]            p_rsp_rdata,
    input logic                     s_req,
    input logic                     s_wr,
    input logic [AW-1:0]            s_addr,
    input logic [BEW-1:0]           s_be,
    input logic [DW-1:0]            s_wdata,
    input logic                     s_done,
    input logic                     en_q,
    input logic                     own_q
);
    import iow_pkg::*;

    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        p_req |=> p_rsp_vld); // R1
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !p_req |=> !p_rsp_vld); // R1
    AST_RSV_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (p_req && p_sel == SEL_DATA && (!p_io || p_from_sec) && !s_req) |=> !s_req); // R3
    AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (p_req && !p_wr && p_sel == SEL_DATA && (!p_io || p_from_sec)) |=> (p_rsp_rdata == '0 && !p_rsp_retry)); // R3
    AST_DIS_NO_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        (p_req && p_sel == SEL_DATA && !en_q && !s_req) |=> !s_req); // R4
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req && !s_done) |=> (s_req && $stable(s_addr) && $stable(s_be) && $stable(s_wr) && $stable(s_wdata))); // R5
    AST_RETRY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req && p_req && p_sel == SEL_DATA && p_io && !p_from_sec && en_q) |=> p_rsp_retry); // R6
    AST_OWN_CLAIM: assert property (@(posedge clk) disable iff (!rst_n)
        (p_req && !p_wr && !p_from_sec && p_sel == SEL_OWN) |=> own_q); // R8
    AST_SHADOW_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (p_req && p_sel == SEL_CTRL) |=> $stable(own_q)); // R10

endmodule

bind iow_ctrl iow_ctrl_chk #(.AW(AW), .DW(DW)) chk_i (
    .clk(clk), .rst_n(rst_n), .p_req(p_req), .p_from_sec(p_from_sec),
    .p_io(p_io), .p_wr(p_wr), .p_sel(p_sel), .p_rsp_vld(p_rsp_vld),
    .p_rsp_retry(p_rsp_retry), .p_rsp_rdata(p_rsp_rdata), .s_req(s_req),
    .s_wr(s_wr), .s_addr(s_addr), .s_be(s_be), .s_wdata(s_wdata),
    .s_done(s_done), .en_q(en_q), .own_q(own_q)
);

// File: tb/iow_ctrl_tb.sv
module iow_ctrl_tb_top;
    import iow_pkg::*;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int BEW = DW / 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic p_req = 1'b0, p_from_sec = 1'b0, p_io = 1'b0, p_wr = 1'b0;
    logic [SELW-1:0] p_sel = '0;
    logic [BEW-1:0]  p_be = '0;
    logic [DW-1:0]   p_wdata = '0;
    logic            p_rsp_vld, p_rsp_retry;
    logic [DW-1:0]   p_rsp_rdata;
    logic            s_req, s_wr;
    logic [AW-1:0]   s_addr;
    logic [BEW-1:0]  s_be;
    logic [DW-1:0]   s_wdata;
    logic            s_done = 1'b0;
    logic [DW-1:0]   s_rdata = '0;

    int compared = 0;
    int mismatched = 0;
    int lat_cnt = 0;
    bit finished = 1'b0;

    logic          q_retry[$];
    logic [DW-1:0] q_rdata[$];
    string         q_tag[$];

    always #5 clk = ~clk;

    iow_ctrl #(.AW(AW), .DW(DW)) dut_i (.*);

    // secondary side model: completes three cycles into a request
    always @(posedge clk) begin
        if (s_done) begin
            s_done  <= 1'b0;
            lat_cnt <= 0;
        end else if (s_req) begin
            lat_cnt <= lat_cnt + 1;
            if (lat_cnt == 2) begin
                s_done  <= 1'b1;
                s_rdata <= s_addr ^ 32'hA5A5_0000;
            end
        end
    end

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input bit sec, input bit io, input bit wr, input logic [SELW-1:0] sel,
                       input logic [BEW-1:0] be, input logic [DW-1:0] wd,
                       input bit exp_retry, input logic [DW-1:0] exp_rd, input string tag);
        @(negedge clk);
        p_req = 1'b1; p_from_sec = sec; p_io = io; p_wr = wr;
        p_sel = sel; p_be = be; p_wdata = wd;
        q_retry.push_back(exp_retry);
        q_rdata.push_back(exp_rd);
        q_tag.push_back(tag);
        @(negedge clk);
        p_req = 1'b0;
    endtask

    // monitor: pops expectations as responses appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (p_rsp_vld) begin
                if (q_tag.size() == 0) begin
                    check("R1 unexpected response", 1, 0);
                end else begin
                    string t;
                    logic r;
                    logic [DW-1:0] d;
                    t = q_tag.pop_front();
                    r = q_retry.pop_front();
                    d = q_rdata.pop_front();
                    check({t, " retry"}, {31'b0, p_rsp_retry}, {31'b0, r});
                    check({t, " rdata"}, p_rsp_rdata, d);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 s_req at reset", {31'b0, s_req}, 0);
        acc(0, 1, 0, SEL_CTRL, 4'hF, 0, 0, 32'h0, "R12 ctrl reset");
        acc(0, 1, 0, SEL_ADDR, 4'hF, 0, 0, 32'h0, "R12 addr reset");
        acc(1, 1, 0, SEL_OWN,  4'hF, 0, 0, 32'h0, "R8 secondary own read");
        acc(0, 1, 0, SEL_CTRL, 4'hF, 0, 0, 32'h0, "R8 own untouched by secondary");
        acc(0, 1, 0, SEL_OWN,  4'hF, 0, 0, 32'h0, "R8 own first claim");
        acc(0, 1, 0, SEL_CTRL, 4'hF, 0, 0, 32'h100, "R10 shadow shows own");
        acc(0, 1, 0, SEL_CTRL, 4'hF, 0, 0, 32'h100, "R10 shadow read again");
        acc(0, 1, 0, SEL_OWN,  4'hF, 0, 0, 32'h1, "R8 own second claim");
        acc(0, 1, 1, SEL_OWN,  4'hF, 0, 0, 32'h0, "R2 own write ignored");
        acc(0, 1, 0, SEL_OWN,  4'hF, 0, 0, 32'h1, "R2 own after write");
        // enable clear: data accesses reserved
        acc(0, 1, 0, SEL_DATA, 4'hF, 0, 0, 32'h0, "R4 disabled data read");
        @(negedge clk);
        check("R4 no launch when disabled", {31'b0, s_req}, 0);
        // own set, config writes still honoured
        acc(0, 1, 1, SEL_CTRL, 4'h0, 32'h1, 0, 32'h0, "R11 ctrl write");
        acc(0, 1, 1, SEL_ADDR, 4'h0, 32'h0000_1236, 0, 32'h0, "R11 addr write");
        acc(0, 1, 0, SEL_CTRL, 4'hF, 0, 0, 32'h101, "R11 ctrl readback");
        acc(0, 1, 0, SEL_ADDR, 4'hF, 0, 0, 32'h0000_1236, "R11 addr readback");
        // reserved accesses
        acc(0, 0, 1, SEL_DATA, 4'h3, 32'h1111_2222, 0, 32'h0, "R3 memory-type write");
        acc(1, 1, 0, SEL_DATA, 4'hF, 0, 0, 32'h0, "R3 secondary data read");
        @(negedge clk);
        check("R3 no launch", {31'b0, s_req}, 0);
        // write transaction with mismatched low address bits
        acc(0, 1, 1, SEL_DATA, 4'h3, 32'hCAFE_F00D, 1, 32'h0, "R6 launch write retried");
        check("R5 s_req raised", {31'b0, s_req}, 1);
        check("R5 s_addr verbatim", s_addr, 32'h0000_1236);
        check("R5 s_be", {28'b0, s_be}, 32'h3);
        check("R5 s_wr", {31'b0, s_wr}, 1);
        check("R5 s_wdata", s_wdata, 32'hCAFE_F00D);
        acc(0, 1, 1, SEL_DATA, 4'h3, 32'hCAFE_F00D, 1, 32'h0, "R6 repeat while busy");
        repeat (8) @(negedge clk);
        check("R5 request dropped after done", {31'b0, s_req}, 0);
        acc(0, 1, 0, SEL_DATA, 4'h3, 0, 1, 32'h0, "R6 direction mismatch retried");
        acc(0, 1, 1, SEL_DATA, 4'hF, 32'hCAFE_F00D, 1, 32'h0, "R6 byte enable mismatch retried");
        acc(0, 1, 0, SEL_CTRL, 4'hF, 0, 0, 32'h101, "R9 own held until delivery");
        acc(0, 1, 1, SEL_DATA, 4'h3, 32'hCAFE_F00D, 0, 32'h0, "R7 write completion");
        acc(0, 1, 0, SEL_CTRL, 4'hF, 0, 0, 32'h001, "R9 own cleared on delivery");
        // read transaction
        acc(0, 1, 1, SEL_ADDR, 4'hF, 32'h0000_0040, 0, 32'h0, "R2 addr write");
        acc(0, 1, 0, SEL_DATA, 4'hF, 0, 1, 32'h0, "R6 launch read retried");
        check("R5 read s_wr", {31'b0, s_wr}, 0);
        check("R5 read s_addr", s_addr, 32'h0000_0040);
        repeat (8) @(negedge clk);
        acc(0, 0, 0, SEL_DATA, 4'hF, 0, 0, 32'h0, "R3 memory read reads zero");
        acc(0, 1, 0, SEL_DATA, 4'hF, 0, 0, 32'hA5A5_0040, "R7 read completion data");
        acc(0, 1, 0, SEL_DATA, 4'hF, 0, 1, 32'h0, "R7 free to launch again");
        repeat (8) @(negedge clk);
        acc(0, 1, 0, SEL_DATA, 4'hF, 0, 0, 32'hA5A5_0040, "R7 second completion");
        repeat (3) @(negedge clk);
        check("R1 all responses seen", q_tag.size(), 0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule